// File: doc/BRIEF.md
# Write Collector and Program-Cycle Sequencer

This block sits behind the serial front end of a small non-volatile memory. After an address has been loaded for a write command, it gathers the data bytes into a slot buffer. When the STOP event arrives, it commits them to the storage array. A commit runs as a self-timed cycle. First, the buffer is scanned once and one array write request is issued per held byte. Then a program-time counter runs. The busy output stays high from the cycle after STOP until the counter expires. While busy is high, every input is ignored.

The MODE level is sampled when the address is loaded, and it selects how bytes are laid out. With MODE low (row mode), bytes fill the 16-byte row that holds the start address. Only the low four address bits step, so a long transfer wraps around inside that row. With MODE high (burst mode), up to eight bytes go to consecutive addresses from any start. If the held bytes straddle two rows, the program time doubles. A lone byte lands at the start address in either mode. Bytes flagged as protected are buffered but never written. The MODE pin should be tied high when it is not driven.

Top module: `wrbuf_seq`

## Requirements
- R1: While reset is held and after its release with no stimulus, `busy` and `wr_req` are 0.
- R2: In row mode (`mode_hi`=0 when `addr_vld` is high), byte k (counting from 0) targets address {start[10:4], (start[3:0]+k) mod 16}. A later byte with the same target replaces the earlier one, so at most 16 writes are issued.
- R3: In burst mode (`mode_hi`=1 when `addr_vld` is high), byte k targets (start + (k mod 8)) mod 2048. A ninth or later byte replaces the byte 8 positions earlier, so at most 8 writes are issued.
- R4: A transfer of exactly one byte writes that byte to the start address with the same timing whatever the mode.
- R5: No write request appears before STOP. A STOP with no bytes collected starts no cycle.
- R6: `busy` rises in the cycle after the committing STOP. For the next 16 cycles, buffer slots 0 to 15 are scanned one per cycle, and `wr_req` is high with `wr_addr`/`wr_data` for each slot that holds a byte. Slot order is ascending low address bits in row mode and ascending offset from the start in burst mode.
- R7: `busy` stays high for 16 + PROG_CYC cycles. In burst mode, when the first and last held bytes lie in different 16-byte rows (address bits 10:4 differ), it stays high for 16 + 2*PROG_CYC cycles.
- R8: A byte strobed with `byte_prot`=1 issues no write request. An overwriting byte replaces the flag too.
- R9: While `busy` is high, address loads, bytes, START and STOP have no effect: no later write or cycle comes from them.
- R10: A `start_evt` while collecting, before STOP, discards the collected bytes. A following STOP then starts no cycle.
- R11: A byte strobe in the same cycle as STOP is buffered and included in the commit, both in its writes and in the row-span test.
- R12: A change of `mode_hi` after the address load has no effect on the current transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Load a start address and begin collecting |
| addr_in | input | ADDR_W | Start address |
| mode_hi | input | 1 | 1 = burst mode, 0 = row mode, sampled with `addr_vld` |
| start_evt | input | 1 | START seen on the bus; cancels collection |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte |
| byte_prot | input | 1 | Target of this byte is protected |
| stop_evt | input | 1 | STOP seen on the bus; commits collected bytes |
| wr_req | output | 1 | Array write request |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | DATA_W | Array write data |
| busy | output | 1 | Program cycle in progress |

## Verification
Two functions can fall in the same cycle: the last byte strobe and the committing STOP. A burst transfer is sent whose final byte is strobed together with STOP and crosses into the next row. The writes must include that byte, and the busy window must take the doubled length. The other collision is stimulus arriving while a cycle runs. A full transfer is driven inside the busy window, and afterwards the bench checks that no second cycle and no stray write appear. A behavioural model in the bench predicts `busy`, `wr_req`, `wr_addr` and `wr_data` for every cycle, and these predictions are compared with the design on every clock.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FILL  = 2'd1,
    SEQ_DRAIN = 2'd2,
    SEQ_PROG  = 2'd3
  } seq_st_t;

endpackage

// File: rtl/wbs_slot_buf.sv
module wbs_slot_buf #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(SLOTS)-1:0] widx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wprot,
  input  logic [$clog2(SLOTS)-1:0] ridx,
  output logic                     rvld,
  output logic                     rprot,
  output logic [DATA_W-1:0]        rdata
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [SLOTS-1:0]  vld_vec;
  logic [SLOTS-1:0]  prot_vec;
  logic [DATA_W-1:0] data_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = we && (widx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        vld_vec[s]  <= 1'b0;
        prot_vec[s] <= 1'b0;
        data_arr[s] <= '0;
      end else if (hit) begin
        vld_vec[s]  <= 1'b1;
        prot_vec[s] <= wprot;
        data_arr[s] <= wdata;
      end
    end
  end

  assign rvld  = vld_vec[ridx];
  assign rprot = prot_vec[ridx];
  assign rdata = data_arr[ridx];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_vec == '0)); // R10

endmodule

// File: rtl/wbs_prog_timer.sv
module wbs_prog_timer #(
  parameter int PROG_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic long_sel,
  output logic running,
  output logic done
);
  localparam int LIM_MAX = 2 * PROG_CYC;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(PROG_CYC);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LIM_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign done = running && (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= LIM_SHORT;
    end else if (kick) begin
      running <= 1'b1;
      cnt_q   <= '0;
      lim_q   <= long_sel ? LIM_LONG : LIM_SHORT;
    end else if (running) begin
      if (done) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < lim_q)); // R7
  AST_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !running); // R7

endmodule

// File: rtl/wbs_fill_ctrl.sv
module wbs_fill_ctrl
  import wbs_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ROW_W     = 4,
  parameter int MULTI_MAX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_vld,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic                 mode_hi,
  input  logic                 start_evt,
  input  logic                 byte_vld,
  input  logic                 stop_evt,
  input  logic                 slot_vld,
  input  logic                 slot_prot,
  input  logic [DATA_W-1:0]    slot_data,
  input  logic                 prog_done,
  output logic                 buf_clr,
  output logic                 buf_we,
  output logic [ROW_W-1:0]     buf_widx,
  output logic [ROW_W-1:0]     drain_idx,
  output logic                 timer_kick,
  output logic                 timer_long,
  output logic                 wr_req,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 busy
);
  localparam int HELD_W = $clog2(MULTI_MAX + 1);
  localparam logic [ROW_W-1:0]  LAST_SLOT  = '1;
  localparam logic [ROW_W-1:0]  MULTI_LAST = ROW_W'(MULTI_MAX - 1);
  localparam logic [HELD_W-1:0] HELD_CAP   = HELD_W'(MULTI_MAX);

  seq_st_t            st_q, st_n;
  logic [ADDR_W-1:0]  start_q;
  logic               multi_q;
  logic [ROW_W-1:0]   ptr_q;
  logic [HELD_W-1:0]  held_q;
  logic               has_byte_q;
  logic               long_q;
  logic [ROW_W-1:0]   didx_q;

  logic               load_now;
  logic               commit_now;
  logic [HELD_W-1:0]  held_inc;
  logic [HELD_W-1:0]  held_after;

  // Next slot after p: wraps in the row, or within the burst window.
  function automatic logic [ROW_W-1:0] step_slot(input logic [ROW_W-1:0] p,
                                                 input logic burst);
    if (burst && (p == MULTI_LAST)) return '0;
    return p + ROW_W'(1);
  endfunction

  // Array address of buffer slot s for a transfer started at a.
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [ROW_W-1:0] s,
                                                  input logic burst);
    if (burst) return a + ADDR_W'(s);
    return {a[ADDR_W-1:ROW_W], s};
  endfunction

  // True when n bytes from a end in a different row than they start.
  function automatic logic spans_rows(input logic [ADDR_W-1:0] a,
                                      input logic [HELD_W-1:0] n);
    logic [ADDR_W-1:0] last;
    last = a + ADDR_W'(n) - ADDR_W'(1);
    return a[ADDR_W-1:ROW_W] != last[ADDR_W-1:ROW_W];
  endfunction

  assign held_inc   = (held_q == HELD_CAP) ? held_q : held_q + HELD_W'(1);
  assign held_after = byte_vld ? held_inc : held_q;

  always_comb begin
    st_n       = st_q;
    load_now   = 1'b0;
    buf_clr    = 1'b0;
    buf_we     = 1'b0;
    commit_now = 1'b0;
    timer_kick = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (addr_vld) begin
          st_n     = SEQ_FILL;
          load_now = 1'b1;
          buf_clr  = 1'b1;
        end
      end
      SEQ_FILL: begin
        if (addr_vld) begin
          load_now = 1'b1;
          buf_clr  = 1'b1;
        end else if (start_evt) begin
          st_n    = SEQ_IDLE;
          buf_clr = 1'b1;
        end else begin
          buf_we = byte_vld;
          if (stop_evt) begin
            if (has_byte_q || byte_vld) begin
              st_n       = SEQ_DRAIN;
              commit_now = 1'b1;
            end else begin
              st_n = SEQ_IDLE;
            end
          end
        end
      end
      SEQ_DRAIN: begin
        if (didx_q == LAST_SLOT) begin
          st_n       = SEQ_PROG;
          timer_kick = 1'b1;
        end
      end
      SEQ_PROG: begin
        if (prog_done) st_n = SEQ_IDLE;
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      start_q    <= '0;
      multi_q    <= 1'b0;
      ptr_q      <= '0;
      held_q     <= '0;
      has_byte_q <= 1'b0;
      long_q     <= 1'b0;
      didx_q     <= '0;
    end else begin
      st_q <= st_n;
      if (load_now) begin
        start_q    <= addr_in;
        multi_q    <= mode_hi;
        ptr_q      <= mode_hi ? '0 : addr_in[ROW_W-1:0];
        held_q     <= '0;
        has_byte_q <= 1'b0;
      end else if (buf_we) begin
        ptr_q      <= step_slot(ptr_q, multi_q);
        held_q     <= held_inc;
        has_byte_q <= 1'b1;
      end
      if (commit_now) begin
        long_q <= multi_q && spans_rows(start_q, held_after);
        didx_q <= '0;
      end else if (st_q == SEQ_DRAIN) begin
        didx_q <= didx_q + ROW_W'(1);
      end
    end
  end

  assign buf_widx   = ptr_q;
  assign drain_idx  = didx_q;
  assign timer_long = long_q;
  assign busy       = (st_q == SEQ_DRAIN) || (st_q == SEQ_PROG);
  assign wr_req     = (st_q == SEQ_DRAIN) && slot_vld && !slot_prot;
  assign wr_addr    = slot_addr(start_q, didx_q, multi_q);
  assign wr_data    = slot_data;

  AST_REQ_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy); // R6
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !multi_q) |-> (wr_addr[ADDR_W-1:ROW_W] == start_q[ADDR_W-1:ROW_W])); // R2
  AST_BURST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && multi_q) |-> (didx_q < ROW_W'(MULTI_MAX))); // R3
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !slot_prot); // R8
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt)); // R5
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy); // R7
  AST_INPUTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(start_q) && $stable(multi_q))); // R9

endmodule

// File: rtl/wrbuf_seq.sv
module wrbuf_seq #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ROW_W     = 4,
  parameter int MULTI_MAX = 8,
  parameter int PROG_CYC  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mode_hi,
  input  logic              start_evt,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_prot,
  input  logic              stop_evt,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy
);
  localparam int SLOTS = 1 << ROW_W;

  logic             buf_clr;
  logic             buf_we;
  logic [ROW_W-1:0] buf_widx;
  logic [ROW_W-1:0] drain_idx;
  logic             slot_vld;
  logic             slot_prot;
  logic [DATA_W-1:0] slot_data;
  logic             timer_kick;
  logic             timer_long;
  logic             timer_run;
  logic             prog_done;

  wbs_fill_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .MULTI_MAX(MULTI_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .addr_vld(addr_vld), .addr_in(addr_in), .mode_hi(mode_hi),
    .start_evt(start_evt), .byte_vld(byte_vld), .stop_evt(stop_evt),
    .slot_vld(slot_vld), .slot_prot(slot_prot), .slot_data(slot_data),
    .prog_done(prog_done),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_widx(buf_widx),
    .drain_idx(drain_idx), .timer_kick(timer_kick), .timer_long(timer_long),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );

  wbs_slot_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .we(buf_we), .widx(buf_widx), .wdata(byte_data), .wprot(byte_prot),
    .ridx(drain_idx), .rvld(slot_vld), .rprot(slot_prot), .rdata(slot_data)
  );

  wbs_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(timer_kick), .long_sel(timer_long),
    .running(timer_run), .done(prog_done)
  );

  AST_RUN_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    timer_run |-> busy); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy); // R7

endmodule

// File: tb/wrbuf_seq_tb_top.sv
`timescale 1ns/1ps
module wrbuf_seq_tb_top;
  localparam int PC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_vld = 1'b0;
  logic [10:0] addr_in = '0;
  logic        mode_hi = 1'b1;
  logic        start_evt = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_prot = 1'b0;
  logic        stop_evt = 1'b0;
  logic        wr_req;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy;

  int errors = 0;
  int checks = 0;
  int obs_wr = 0;
  int obs_busy = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wrbuf_seq #(.PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
    .mode_hi(mode_hi), .start_evt(start_evt), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_prot(byte_prot), .stop_evt(stop_evt),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );

  // Behavioural reference model
  int  m_left = 0, m_total = 0, m_k = 0;
  bit  m_coll = 0, m_multi = 0;
  int  m_start = 0;
  bit  ev [16];
  bit  ep [16];
  int  ed [16];

  task automatic m_clear();
    for (int i = 0; i < 16; i++) begin ev[i] = 0; ep[i] = 0; ed[i] = 0; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_coll = 0; m_k = 0; m_clear();
    end else if (m_left > 0) begin
      m_left--;
    end else if (addr_vld) begin
      m_coll = 1; m_start = int'(addr_in); m_multi = mode_hi; m_k = 0; m_clear();
    end else if (start_evt) begin
      m_coll = 0; m_clear();
    end else if (m_coll) begin
      if (byte_vld) begin
        int s;
        s = m_multi ? (m_k % 8) : ((m_start + m_k) % 16);
        ev[s] = 1; ep[s] = byte_prot; ed[s] = int'(byte_data);
        m_k++;
      end
      if (stop_evt) begin
        m_coll = 0;
        if (m_k > 0) begin
          int n, last;
          bit lng;
          n = (m_k < 8) ? m_k : 8;
          last = (m_start + n - 1) % 2048;
          lng = m_multi && ((m_start / 16) != (last / 16));
          m_total = 16 + (lng ? 2 * PC : PC);
          m_left = m_total;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      bit e_busy, e_req;
      int pos, e_addr;
      string tag;
      tag = rst_n ? cur_req : "R1";
      e_busy = (m_left > 0);
      pos = m_total - m_left;
      e_req = e_busy && (pos < 16) && ev[pos % 16] && !ep[pos % 16];
      e_addr = m_multi ? ((m_start + pos) % 2048) : ((m_start / 16) * 16 + (pos % 16));
      checks++;
      if (busy !== e_busy || wr_req !== e_req ||
          (e_req && (int'(wr_addr) != e_addr || int'(wr_data) != ed[pos % 16]))) begin
        errors++;
        $display("FAIL %s cycle %0d: busy=%0b req=%0b addr=%h data=%h expected busy=%0b req=%0b addr=%h data=%h",
                 tag, cycles, busy, wr_req, wr_addr, wr_data, e_busy, e_req, e_addr,
                 (e_req ? ed[pos % 16] : 0));
      end
      if (wr_req === 1'b1) obs_wr++;
      if (busy === 1'b1) obs_busy++;
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic load(int a, bit m);
    @(negedge clk);
    addr_vld = 1; addr_in = 11'(a); mode_hi = m;
    @(negedge clk);
    addr_vld = 0;
  endtask

  task automatic put(int d, bit p, bit with_stop);
    @(negedge clk);
    byte_vld = 1; byte_data = 8'(d); byte_prot = p; stop_evt = with_stop;
    @(negedge clk);
    byte_vld = 0; byte_prot = 0; stop_evt = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1; @(negedge clk); stop_evt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_evt = 1; @(negedge clk); start_evt = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(string req, int a, bit m, int n, int base, int pmask, bit merge);
    cur_req = req; obs_wr = 0; obs_busy = 0;
    load(a, m);
    for (int i = 0; i < n; i++)
      put(base + i, (pmask >> (i % 32)) & 1, merge && (i == n - 1));
    if (!merge) pulse_stop();
    settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_eq("R1", "busy in reset", int'(busy), 0);
    check_eq("R1", "wr_req in reset", int'(wr_req), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_eq("R1", "busy after reset", int'(busy), 0);

    xfer("R2", 'h13C, 0, 6, 'h40, 0, 0);
    check_eq("R2", "row-mode writes", obs_wr, 6);
    check_eq("R7", "row-mode busy length", obs_busy, 16 + PC);

    xfer("R2", 'h200, 0, 18, 'h80, 0, 0);
    check_eq("R2", "row wrap writes", obs_wr, 16);

    xfer("R3", 'h040, 1, 5, 'h10, 0, 0);
    check_eq("R3", "burst writes", obs_wr, 5);
    check_eq("R7", "burst one-row busy", obs_busy, 16 + PC);

    xfer("R7", 'h07D, 1, 8, 'h20, 0, 0);
    check_eq("R7", "burst two-row busy", obs_busy, 16 + 2 * PC);
    check_eq("R3", "burst 8 writes", obs_wr, 8);

    xfer("R3", 'h7FE, 1, 10, 'hA0, 0, 0);
    check_eq("R3", "burst overflow writes", obs_wr, 8);
    check_eq("R7", "top-wrap span busy", obs_busy, 16 + 2 * PC);

    xfer("R4", 'h0F5, 0, 1, 'h5A, 0, 0);
    check_eq("R4", "single byte row mode writes", obs_wr, 1);
    check_eq("R4", "single byte row mode busy", obs_busy, 16 + PC);
    xfer("R4", 'h0F5, 1, 1, 'hA5, 0, 0);
    check_eq("R4", "single byte burst mode writes", obs_wr, 1);
    check_eq("R4", "single byte burst mode busy", obs_busy, 16 + PC);

    xfer("R5", 'h321, 1, 0, 0, 0, 0);
    check_eq("R5", "empty stop busy", obs_busy, 0);

    xfer("R8", 'h150, 0, 4, 'h70, 'b0010, 0);
    check_eq("R8", "writes with protected byte", obs_wr, 3);
    xfer("R8", 'h3F0, 1, 9, 'h30, 'b1, 0);
    check_eq("R8", "overwritten protected slot writes", obs_wr, 8);

    cur_req = "R10"; obs_wr = 0; obs_busy = 0;
    load('h111, 0); put('h01, 0, 0); put('h02, 0, 0);
    pulse_start(); pulse_stop(); settle();
    check_eq("R10", "cancelled busy", obs_busy, 0);
    load('h222, 1); pulse_start(); pulse_stop(); settle();
    check_eq("R10", "cancel before data busy", obs_busy, 0);

    xfer("R11", 'h0EE, 1, 3, 'hC0, 0, 1);
    check_eq("R11", "merged byte writes", obs_wr, 3);
    check_eq("R11", "merged byte span busy", obs_busy, 16 + 2 * PC);

    cur_req = "R12"; obs_wr = 0; obs_busy = 0;
    load('h33E, 0);
    @(negedge clk); mode_hi = 1;
    put('h11, 0, 0); put('h12, 0, 0); put('h13, 0, 0);
    pulse_stop(); settle();
    check_eq("R12", "late mode change busy", obs_busy, 16 + PC);
    check_eq("R12", "late mode change writes", obs_wr, 3);

    cur_req = "R9"; obs_wr = 0; obs_busy = 0;
    load('h0A0, 0); put('h77, 0, 1);
    load('h100, 1); put('h01, 0, 0); put('h02, 0, 0);
    pulse_stop(); pulse_start(); pulse_stop();
    settle();
    repeat (10) @(negedge clk);
    check_eq("R9", "writes with busy stimulus", obs_wr, 1);
    check_eq("R9", "busy with busy stimulus", obs_busy, 16 + PC);

    summary();
  end

endmodule